// File: doc/BRIEF.md
# Display Register Window Bridge

This block sits behind a 4 KB memory-mapped register window of a display controller. Each accepted bus request is decoded by offset and handed to one of three targets. The first is a byte-wide legacy port channel that reaches the classic display I/O ports. The second is a 16-bit channel into the mode-setting register file. The third is a small bank of 32-bit extension registers held inside the bridge. One extension register chooses the byte order of the framebuffer. Its state leaves the block as a flag that steers a byte-lane swapper elsewhere in the display path.

A 16-bit write into the port window is split into two port writes on consecutive cycles: the low byte goes to the addressed port, then the high byte goes to the next port. An index port and its data port can therefore be loaded by a single bus write. While a port or mode-register access is in progress the bridge drops its ready output, so requests never overlap. Reads of the reserved low window, of the extension bank and of unmapped offsets are answered from inside the bridge. The bridge also drives a constant revision code that tells software the extension bank is present.

Top module: `disp_mmio_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, port_valid, reg_valid and rsp_valid are 0, and fb_big_endian is 0 (little-endian).
- R2: A write to an offset from 0x000 to 0x3FF produces no port or register strobe, and a read there returns 0.
- R3: A byte access at offset 0x400+k (k from 0 to 31) drives one strobe cycle with port_addr = 0x3C0+k, in the cycle after acceptance. A write carries req_wdata[7:0]. A read returns the port byte in rsp_rdata[7:0], with rsp_valid two cycles after acceptance.
- R4: A write with req_size 1 (16-bit) or 2 (32-bit) at port offset k<31 drives two strobes in consecutive cycles. The first goes to port 0x3C0+k with req_wdata[7:0]. The second goes to port 0x3C1+k with req_wdata[15:8].
- R5: req_ready is 0 from the cycle after a port or mode-register access is accepted until the cycle after its last strobe. This is one busy cycle for a single strobe and two for a split one.
- R6: A 16-bit read at port offset k<31 returns port 0x3C0+k in rsp_rdata[7:0] and port 0x3C1+k in rsp_rdata[15:8], with rsp_valid three cycles after acceptance.
- R7: A 16-bit write at offset 0x41F drives only one strobe, to port 0x3DF with req_wdata[7:0]. No port outside 0x3C0 to 0x3DF is ever strobed.
- R8: Offsets 0x500 to 0x515 reach mode register n = (offset - 0x500) >> 1 with 16-bit data through one reg_valid strobe in the cycle after acceptance. Reads return reg_rdata in rsp_rdata[15:0], two cycles after acceptance.
- R9: Offset 0x600 reads 8, and writes to it change nothing.
- R10: A write of 0xBEBEBEBE to offset 0x604 sets fb_big_endian to 1. A write of 0x1E1E1E1E clears it. Any other value leaves it unchanged. Reads of 0x604 return the code for the current setting.
- R11: dev_revision is constantly 2.
- R12: Offsets 0x420 to 0x4FF, 0x516 to 0x5FF and 0x608 to 0xFFF read 0, and writes to them produce no strobe.
- R13: Reads answered inside the bridge (R2, R9, R10, R12) give rsp_valid in the cycle after acceptance and leave req_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_addr | input | 12 | Byte offset into the window |
| req_wdata | input | 32 | Write data, least significant byte at bits 7:0 |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data |
| port_valid | output | 1 | Legacy port strobe |
| port_write | output | 1 | Legacy port direction |
| port_addr | output | 10 | Legacy port number |
| port_wdata | output | 8 | Legacy port write byte |
| port_rdata | input | 8 | Legacy port read byte, valid while port_valid is high |
| reg_valid | output | 1 | Mode register strobe |
| reg_write | output | 1 | Mode register direction |
| reg_idx | output | 4 | Mode register number |
| reg_wdata | output | 16 | Mode register write data |
| reg_rdata | input | 16 | Mode register read data, valid while reg_valid is high |
| fb_big_endian | output | 1 | Framebuffer byte order, 1 = big-endian |
| dev_revision | output | 8 | Revision code |

## Verification
A sequencer stuck in a busy state shows at once: req_ready stays low, and the next request waits. A lost split flag shows in the very next cycle as a missing or extra port strobe. An off-by-one in the port or mode-register offset puts a wrong port_addr or reg_idx on the strobe in the cycle after acceptance. A wrong byte-order state shows on fb_big_endian, and on any read of the order register one cycle after the request.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

  typedef enum logic [2:0] {
    RG_RSVD,
    RG_PORT,
    RG_MODE,
    RG_EXT,
    RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BEAT1,
    ST_BEAT2
  } seq_state_e;

endpackage

// File: rtl/dmb_decode.sv
module dmb_decode
  import dmb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PORT_OFF   = 'h400,
  parameter int PORT_COUNT = 32,
  parameter int MODE_OFF   = 'h500,
  parameter int MODE_COUNT = 11,
  parameter int EXT_OFF    = 'h600,
  parameter int EXT_BYTES  = 8
) (
  input  logic [ADDR_W-1:0]             addr,
  output region_e                       region,
  output logic [$clog2(PORT_COUNT)-1:0] port_idx,
  output logic [$clog2(MODE_COUNT)-1:0] mode_idx,
  output logic                          ext_sel
);

  localparam int PORT_IW = $clog2(PORT_COUNT);
  localparam int MODE_IW = $clog2(MODE_COUNT);
  localparam logic [ADDR_W-1:0] PORT_LO = ADDR_W'(PORT_OFF);
  localparam logic [ADDR_W-1:0] PORT_HI = ADDR_W'(PORT_OFF + PORT_COUNT);
  localparam logic [ADDR_W-1:0] MODE_LO = ADDR_W'(MODE_OFF);
  localparam logic [ADDR_W-1:0] MODE_HI = ADDR_W'(MODE_OFF + 2 * MODE_COUNT);
  localparam logic [ADDR_W-1:0] EXT_LO  = ADDR_W'(EXT_OFF);
  localparam logic [ADDR_W-1:0] EXT_HI  = ADDR_W'(EXT_OFF + EXT_BYTES);

  always_comb begin
    region = RG_NONE;
    if (addr < PORT_LO)
      region = RG_RSVD;
    else if (addr < PORT_HI)
      region = RG_PORT;
    else if (addr >= MODE_LO && addr < MODE_HI)
      region = RG_MODE;
    else if (addr >= EXT_LO && addr < EXT_HI)
      region = RG_EXT;
  end

  assign port_idx = PORT_IW'(addr - PORT_LO);
  assign mode_idx = MODE_IW'((addr - MODE_LO) >> 1);
  assign ext_sel  = addr[2];

endmodule

// File: rtl/dmb_ext_regs.sv
module dmb_ext_regs #(
  parameter int          DATA_W    = 32,
  parameter int          EXT_BYTES = 8,
  parameter logic [31:0] BE_CODE   = 32'hBEBE_BEBE,
  parameter logic [31:0] LE_CODE   = 32'h1E1E_1E1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              big_endian
);

  localparam logic [DATA_W-1:0] SPAN_VAL = DATA_W'(EXT_BYTES);
  localparam logic [DATA_W-1:0] BE_VAL   = DATA_W'(BE_CODE);
  localparam logic [DATA_W-1:0] LE_VAL   = DATA_W'(LE_CODE);

  logic order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= 1'b0;
    end else if (wr_en && sel) begin
      if (wdata == BE_VAL)
        order_q <= 1'b1;
      else if (wdata == LE_VAL)
        order_q <= 1'b0;
    end
  end

  assign rdata      = sel ? (order_q ? BE_VAL : LE_VAL) : SPAN_VAL;
  assign big_endian = order_q;

  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel) |=> $stable(big_endian)); // R10

  AST_ORDER_ODD_CODE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && wdata != BE_VAL && wdata != LE_VAL) |=> $stable(big_endian)); // R10

endmodule

// File: rtl/dmb_seq.sv
module dmb_seq
  import dmb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PORT_COUNT  = 32,
  parameter int PORT_AW     = 10,
  parameter int LEGACY_BASE = 'h3C0,
  parameter int MODE_COUNT  = 11,
  parameter int MODE_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [MODE_W-1:0]             req_wdata,
  input  region_e                       region,
  input  logic [$clog2(PORT_COUNT)-1:0] port_idx,
  input  logic [$clog2(MODE_COUNT)-1:0] mode_idx,
  input  logic [DATA_W-1:0]             ext_rdata,
  output logic                          req_ready,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          port_valid,
  output logic                          port_write,
  output logic [PORT_AW-1:0]            port_addr,
  output logic [7:0]                    port_wdata,
  input  logic [7:0]                    port_rdata,
  output logic                          reg_valid,
  output logic                          reg_write,
  output logic [$clog2(MODE_COUNT)-1:0] reg_idx,
  output logic [MODE_W-1:0]             reg_wdata,
  input  logic [MODE_W-1:0]             reg_rdata
);

  localparam int PORT_IW = $clog2(PORT_COUNT);
  localparam int MODE_IW = $clog2(MODE_COUNT);
  localparam logic [PORT_AW-1:0] PBASE = PORT_AW'(LEGACY_BASE);
  localparam logic [PORT_AW-1:0] PLAST = PORT_AW'(LEGACY_BASE + PORT_COUNT - 1);
  localparam logic [PORT_IW-1:0] IDX_LAST = PORT_IW'(PORT_COUNT - 1);

  seq_state_e          state_q;
  logic                split_q;
  logic                rd_q;
  logic                tgt_mode_q;
  logic [7:0]          hi_byte_q;
  logic [7:0]          lo_byte_q;
  logic                port_valid_q;
  logic                port_write_q;
  logic [PORT_AW-1:0]  port_addr_q;
  logic [7:0]          port_wdata_q;
  logic                reg_valid_q;
  logic                reg_write_q;
  logic [MODE_IW-1:0]  reg_idx_q;
  logic [MODE_W-1:0]   reg_wdata_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;
  logic                wide;

  assign wide = (req_size != SZ_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      split_q      <= 1'b0;
      rd_q         <= 1'b0;
      tgt_mode_q   <= 1'b0;
      hi_byte_q    <= '0;
      lo_byte_q    <= '0;
      port_valid_q <= 1'b0;
      port_write_q <= 1'b0;
      port_addr_q  <= PBASE;
      port_wdata_q <= '0;
      reg_valid_q  <= 1'b0;
      reg_write_q  <= 1'b0;
      reg_idx_q    <= '0;
      reg_wdata_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            rd_q <= !req_write;
            unique case (region)
              RG_PORT: begin
                port_valid_q <= 1'b1;
                port_write_q <= req_write;
                port_addr_q  <= PBASE + PORT_AW'(port_idx);
                port_wdata_q <= req_wdata[7:0];
                hi_byte_q    <= req_wdata[15:8];
                split_q      <= wide && (port_idx != IDX_LAST);
                tgt_mode_q   <= 1'b0;
                state_q      <= ST_BEAT1;
              end
              RG_MODE: begin
                reg_valid_q <= 1'b1;
                reg_write_q <= req_write;
                reg_idx_q   <= mode_idx;
                reg_wdata_q <= req_wdata;
                split_q     <= 1'b0;
                tgt_mode_q  <= 1'b1;
                state_q     <= ST_BEAT1;
              end
              default: begin
                if (!req_write) begin
                  rsp_valid_q <= 1'b1;
                  rsp_rdata_q <= (region == RG_EXT) ? ext_rdata : '0;
                end
              end
            endcase
          end
        end
        ST_BEAT1: begin
          lo_byte_q   <= port_rdata;
          reg_valid_q <= 1'b0;
          if (split_q) begin
            port_addr_q  <= port_addr_q + PORT_AW'(1);
            port_wdata_q <= hi_byte_q;
            state_q      <= ST_BEAT2;
          end else begin
            port_valid_q <= 1'b0;
            state_q      <= ST_IDLE;
            if (rd_q) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= tgt_mode_q ? DATA_W'(reg_rdata) : DATA_W'(port_rdata);
            end
          end
        end
        ST_BEAT2: begin
          port_valid_q <= 1'b0;
          state_q      <= ST_IDLE;
          if (rd_q) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= DATA_W'({port_rdata, lo_byte_q});
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign port_valid = port_valid_q;
  assign port_write = port_write_q;
  assign port_addr  = port_addr_q;
  assign port_wdata = port_wdata_q;
  assign reg_valid  = reg_valid_q;
  assign reg_write  = reg_write_q;
  assign reg_idx    = reg_idx_q;
  assign reg_wdata  = reg_wdata_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(port_valid_q && reg_valid_q)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (port_valid_q || reg_valid_q) |-> !req_ready); // R5

  AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (port_valid_q && $past(port_valid_q)) |-> (port_addr_q == $past(port_addr_q) + PORT_AW'(1))); // R4

  AST_PORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    port_valid_q |-> (port_addr_q >= PBASE && port_addr_q <= PLAST)); // R7

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (rst)
    reg_valid_q |-> (int'(reg_idx_q) < MODE_COUNT)); // R8

  AST_MODE_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
    reg_valid_q |=> !reg_valid_q); // R8

endmodule

// File: rtl/disp_mmio_bridge.sv
module disp_mmio_bridge
  import dmb_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          PORT_OFF    = 'h400,
  parameter int          PORT_COUNT  = 32,
  parameter int          PORT_AW     = 10,
  parameter int          LEGACY_BASE = 'h3C0,
  parameter int          MODE_OFF    = 'h500,
  parameter int          MODE_COUNT  = 11,
  parameter int          MODE_W      = 16,
  parameter int          EXT_OFF     = 'h600,
  parameter int          EXT_BYTES   = 8,
  parameter logic [31:0] BE_CODE     = 32'hBEBE_BEBE,
  parameter logic [31:0] LE_CODE     = 32'h1E1E_1E1E,
  parameter logic [7:0]  REVISION    = 8'd2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          port_valid,
  output logic                          port_write,
  output logic [PORT_AW-1:0]            port_addr,
  output logic [7:0]                    port_wdata,
  input  logic [7:0]                    port_rdata,
  output logic                          reg_valid,
  output logic                          reg_write,
  output logic [$clog2(MODE_COUNT)-1:0] reg_idx,
  output logic [MODE_W-1:0]             reg_wdata,
  input  logic [MODE_W-1:0]             reg_rdata,
  output logic                          fb_big_endian,
  output logic [7:0]                    dev_revision
);

  localparam int PORT_IW = $clog2(PORT_COUNT);
  localparam int MODE_IW = $clog2(MODE_COUNT);

  region_e             region;
  logic [PORT_IW-1:0]  port_idx;
  logic [MODE_IW-1:0]  mode_idx;
  logic                ext_sel;
  logic                ext_wr;
  logic [DATA_W-1:0]   ext_rdata;

  dmb_decode #(
    .ADDR_W(ADDR_W), .PORT_OFF(PORT_OFF), .PORT_COUNT(PORT_COUNT),
    .MODE_OFF(MODE_OFF), .MODE_COUNT(MODE_COUNT),
    .EXT_OFF(EXT_OFF), .EXT_BYTES(EXT_BYTES)
  ) u_decode (
    .addr     (req_addr),
    .region   (region),
    .port_idx (port_idx),
    .mode_idx (mode_idx),
    .ext_sel  (ext_sel)
  );

  assign ext_wr = req_valid && req_ready && req_write && (region == RG_EXT);

  dmb_ext_regs #(
    .DATA_W(DATA_W), .EXT_BYTES(EXT_BYTES), .BE_CODE(BE_CODE), .LE_CODE(LE_CODE)
  ) u_ext (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ext_wr),
    .sel        (ext_sel),
    .wdata      (req_wdata),
    .rdata      (ext_rdata),
    .big_endian (fb_big_endian)
  );

  dmb_seq #(
    .DATA_W(DATA_W), .PORT_COUNT(PORT_COUNT), .PORT_AW(PORT_AW),
    .LEGACY_BASE(LEGACY_BASE), .MODE_COUNT(MODE_COUNT), .MODE_W(MODE_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_wdata  (req_wdata[MODE_W-1:0]),
    .region     (region),
    .port_idx   (port_idx),
    .mode_idx   (mode_idx),
    .ext_rdata  (ext_rdata),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .port_valid (port_valid),
    .port_write (port_write),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_rdata (port_rdata),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  assign dev_revision = REVISION;

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && region != RG_PORT && region != RG_MODE)
      |=> (!port_valid && !reg_valid)); // R2

  AST_INTERNAL_RSP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && region != RG_PORT && region != RG_MODE)
      |=> (rsp_valid && req_ready)); // R13

endmodule

// File: tb/disp_mmio_bridge_test.sv
module disp_mmio_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        port_valid, port_write;
  logic [9:0]  port_addr;
  logic [7:0]  port_wdata, port_rdata;
  logic        reg_valid, reg_write;
  logic [3:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata;
  logic        fb_big_endian;
  logic [7:0]  dev_revision;

  always #10 clk = ~clk;

  disp_mmio_bridge uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .port_valid(port_valid), .port_write(port_write), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fb_big_endian(fb_big_endian), .dev_revision(dev_revision)
  );

  // port and mode register models plus strobe logs
  logic [7:0]  pmem [32];
  logic [15:0] mreg [16];
  int          cyc = 0;
  int          pn = 0, rn = 0;
  logic [9:0]  plog_addr [64];
  logic [7:0]  plog_data [64];
  int          plog_cyc  [64];
  logic [3:0]  rlog_idx  [64];
  logic [15:0] rlog_data [64];

  assign port_rdata = pmem[port_addr[4:0]];
  assign reg_rdata  = mreg[reg_idx];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) pmem[i] = 8'hA0 + 8'(i);
      for (int i = 0; i < 16; i++) mreg[i] = 16'h1000 + 16'(i);
    end else begin
      if (port_valid) begin
        if (port_write) pmem[port_addr[4:0]] = port_wdata;
        plog_addr[pn % 64] = port_addr;
        plog_data[pn % 64] = port_wdata;
        plog_cyc[pn % 64]  = cyc;
        pn = pn + 1;
      end
      if (reg_valid) begin
        if (reg_write) mreg[reg_idx] = reg_wdata;
        rlog_idx[rn % 64]  = reg_idx;
        rlog_data[rn % 64] = reg_wdata;
        rn = rn + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output int busy);
    rd = '0; lat = 0; busy = 0;
    @(negedge clk);
    for (int w = 0; w < 10 && !req_ready; w++) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (!req_ready) busy++;
      if (rsp_valid && lat == 0) begin lat = k; rd = rsp_rdata; end
      if (req_ready && (wr || lat != 0)) break;
    end
  endtask

  // tag, write, size, addr, wdata, expected read data
  localparam int NV = 30;
  localparam logic [82:0] VEC [NV] = '{
    {4'd3,  1'b0, 2'd0, 12'h400, 32'h0,         32'h0000_00A0}, // R3
    {4'd3,  1'b1, 2'd0, 12'h405, 32'h0000_005A, 32'h0},         // R3
    {4'd3,  1'b0, 2'd0, 12'h405, 32'h0,         32'h0000_005A}, // R3
    {4'd4,  1'b1, 2'd1, 12'h410, 32'h0000_BEEF, 32'h0},         // R4
    {4'd4,  1'b0, 2'd0, 12'h410, 32'h0,         32'h0000_00EF}, // R4
    {4'd4,  1'b0, 2'd0, 12'h411, 32'h0,         32'h0000_00BE}, // R4
    {4'd6,  1'b0, 2'd1, 12'h404, 32'h0,         32'h0000_5AA4}, // R6
    {4'd6,  1'b0, 2'd1, 12'h41E, 32'h0,         32'h0000_BFBE}, // R6
    {4'd2,  1'b1, 2'd2, 12'h100, 32'hFFFF_FFFF, 32'h0},         // R2
    {4'd2,  1'b0, 2'd2, 12'h000, 32'h0,         32'h0},         // R2
    {4'd2,  1'b0, 2'd2, 12'h3FC, 32'h0,         32'h0},         // R2
    {4'd9,  1'b0, 2'd2, 12'h600, 32'h0,         32'h0000_0008}, // R9
    {4'd9,  1'b1, 2'd2, 12'h600, 32'h1234_5678, 32'h0},         // R9
    {4'd9,  1'b0, 2'd2, 12'h600, 32'h0,         32'h0000_0008}, // R9
    {4'd10, 1'b0, 2'd2, 12'h604, 32'h0,         32'h1E1E_1E1E}, // R10
    {4'd10, 1'b1, 2'd2, 12'h604, 32'hBEBE_BEBE, 32'h0},         // R10
    {4'd10, 1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE}, // R10
    {4'd10, 1'b1, 2'd2, 12'h604, 32'h1234_5678, 32'h0},         // R10
    {4'd10, 1'b0, 2'd2, 12'h604, 32'h0,         32'hBEBE_BEBE}, // R10
    {4'd10, 1'b1, 2'd2, 12'h604, 32'h1E1E_1E1E, 32'h0},         // R10
    {4'd10, 1'b0, 2'd2, 12'h604, 32'h0,         32'h1E1E_1E1E}, // R10
    {4'd8,  1'b0, 2'd1, 12'h500, 32'h0,         32'h0000_1000}, // R8
    {4'd8,  1'b1, 2'd1, 12'h514, 32'h0000_CAFE, 32'h0},         // R8
    {4'd8,  1'b0, 2'd1, 12'h514, 32'h0,         32'h0000_CAFE}, // R8
    {4'd8,  1'b0, 2'd1, 12'h502, 32'h0,         32'h0000_1001}, // R8
    {4'd12, 1'b0, 2'd2, 12'h420, 32'h0,         32'h0},         // R12
    {4'd12, 1'b0, 2'd1, 12'h516, 32'h0,         32'h0},         // R12
    {4'd12, 1'b0, 2'd2, 12'h608, 32'h0,         32'h0},         // R12
    {4'd12, 1'b0, 2'd2, 12'hFFC, 32'h0,         32'h0},         // R12
    {4'd3,  1'b0, 2'd0, 12'h41F, 32'h0,         32'h0000_00BF}  // R3
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, busy, p0, r0;

    do_reset();
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "strobes/rsp", {29'd0, port_valid, reg_valid, rsp_valid}, 32'd0);
    chk("R1", "fb_big_endian", 32'(fb_big_endian), 32'd0);
    chk("R11", "dev_revision", 32'(dev_revision), 32'd2);

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      access(v[78], v[77:76], v[75:64], v[63:32], rd, lat, busy);
      if (!v[78]) begin
        chk($sformatf("R%0d", v[82:79]), $sformatf("vector %0d rsp seen", i), 32'(lat != 0), 32'd1);
        chk($sformatf("R%0d", v[82:79]), $sformatf("vector %0d data", i), rd, v[31:0]);
      end
    end

    // R4 R5: split write order, timing and busy window
    p0 = pn;
    access(1'b1, 2'd1, 12'h408, 32'h0000_3344, rd, lat, busy);
    chk("R4", "split strobes", 32'(pn - p0), 32'd2);
    chk("R4", "first port", 32'(plog_addr[p0 % 64]), 32'h3C8);
    chk("R4", "first byte", 32'(plog_data[p0 % 64]), 32'h44);
    chk("R4", "second port", 32'(plog_addr[(p0 + 1) % 64]), 32'h3C9);
    chk("R4", "second byte", 32'(plog_data[(p0 + 1) % 64]), 32'h33);
    chk("R4", "back to back", 32'(plog_cyc[(p0 + 1) % 64] - plog_cyc[p0 % 64]), 32'd1);
    chk("R5", "split busy cycles", 32'(busy), 32'd2);

    // R3 R5: single byte write
    p0 = pn;
    access(1'b1, 2'd0, 12'h40C, 32'h0000_9977, rd, lat, busy);
    chk("R3", "byte strobes", 32'(pn - p0), 32'd1);
    chk("R3", "byte port", 32'(plog_addr[p0 % 64]), 32'h3CC);
    chk("R3", "byte data", 32'(plog_data[p0 % 64]), 32'h77);
    chk("R5", "byte busy cycles", 32'(busy), 32'd1);

    // R7: wide write at the last port
    p0 = pn;
    access(1'b1, 2'd1, 12'h41F, 32'h0000_1122, rd, lat, busy);
    chk("R7", "edge strobes", 32'(pn - p0), 32'd1);
    chk("R7", "edge port", 32'(plog_addr[p0 % 64]), 32'h3DF);
    chk("R7", "edge data", 32'(plog_data[p0 % 64]), 32'h22);
    chk("R7", "edge busy", 32'(busy), 32'd1);
    access(1'b0, 2'd0, 12'h41F, 32'h0, rd, lat, busy);
    chk("R7", "last port readback", rd, 32'h22);

    // R2 R12: writes outside the port and mode windows strobe nothing
    p0 = pn; r0 = rn;
    access(1'b1, 2'd1, 12'h200, 32'h0000_5555, rd, lat, busy);
    chk("R2", "reserved write strobes", 32'((pn - p0) + (rn - r0)), 32'd0);
    chk("R2", "reserved write busy", 32'(busy), 32'd0);
    access(1'b1, 2'd1, 12'h420, 32'h0000_6666, rd, lat, busy);
    access(1'b1, 2'd1, 12'h516, 32'h0000_6666, rd, lat, busy);
    chk("R12", "unmapped write strobes", 32'((pn - p0) + (rn - r0)), 32'd0);

    // R13 R3 R6 R8: response latencies
    access(1'b0, 2'd2, 12'h600, 32'h0, rd, lat, busy);
    chk("R13", "internal latency", 32'(lat), 32'd1);
    chk("R13", "internal busy", 32'(busy), 32'd0);
    access(1'b0, 2'd0, 12'h40C, 32'h0, rd, lat, busy);
    chk("R3", "byte read latency", 32'(lat), 32'd2);
    chk("R3", "byte read data", rd, 32'h77);
    access(1'b0, 2'd1, 12'h408, 32'h0, rd, lat, busy);
    chk("R6", "wide read latency", 32'(lat), 32'd3);
    chk("R6", "wide read data", rd, 32'h3344);
    access(1'b0, 2'd1, 12'h506, 32'h0, rd, lat, busy);
    chk("R8", "mode read latency", 32'(lat), 32'd2);
    chk("R8", "mode read data", rd, 32'h1003);

    // R8: mode write reaches register number (0x50A-0x500)>>1 = 5
    r0 = rn;
    access(1'b1, 2'd1, 12'h50A, 32'h0000_7777, rd, lat, busy);
    chk("R8", "mode strobes", 32'(rn - r0), 32'd1);
    chk("R8", "mode index", 32'(rlog_idx[r0 % 64]), 32'd5);
    chk("R8", "mode data", 32'(rlog_data[r0 % 64]), 32'h7777);

    // R10: flag pin follows the codes
    access(1'b1, 2'd2, 12'h604, 32'hBEBE_BEBE, rd, lat, busy);
    chk("R10", "flag big", 32'(fb_big_endian), 32'd1);
    access(1'b1, 2'd2, 12'h604, 32'hBEBE_BEBF, rd, lat, busy);
    chk("R10", "flag kept", 32'(fb_big_endian), 32'd1);

    // R1: reset returns to little-endian
    do_reset();
    chk("R1", "flag after reset", 32'(fb_big_endian), 32'd0);
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    access(1'b0, 2'd2, 12'h604, 32'h0, rd, lat, busy);
    chk("R1", "order code after reset", rd, 32'h1E1E_1E1E);
    chk("R11", "dev_revision after reset", 32'(dev_revision), 32'd2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule